// File: doc/BRIEF.md
# Exception Vector and Cause Unit

This unit turns a one-cycle exception request into everything the processor front end needs to enter a handler. From the kind of exception and a snapshot of the machine state (current PC, delay-slot and compressed-ISA flags, the exception-level, error-level and bootstrap-vector status bits, the exception base, and the vectored-interrupt settings with the pending interrupt lines) it computes the handler PC, the 5-bit cause code and the return address. It keeps the normal, error and debug return-address registers and the branch-delay cause bit.

The surrounding pipeline samples the status fields from its own status register, pulses `req` with a kind code, and one cycle later gets `vec_valid` together with the handler PC and the new status bits. These are written back to the status register. Exception return and instruction execution live elsewhere.

Top module: `excvec_unit`

## Requirements
- R1: The return address is `cur_pc` ORed with `isa_compact` in bit 0. When `in_dly` is 1 it is then reduced by 2 if `dly_compact` is 1, and by 4 otherwise.
- R2: For a general exception (kind 0..17), `epc` takes the return address and `cause_bd` takes `in_dly`, but only if `st_exl` was 0. Otherwise both keep their values. In either case `new_exl` and `new_kern` become 1, and `new_erl`/`new_bev` copy `st_erl`/`st_bev`.
- R3: The handler offset of a general exception is 0x180. A TLB load or TLB store (kinds 2, 3) with `refill`=1 and `st_exl`=0 uses offset 0x000 instead; any other kind ignores `refill`.
- R4: An interrupt (kind 0) uses offset 0x180 when `int_iv`=0, and 0x200 when `int_iv`=1. When `vec_mode`=1 the offset is instead 0x200 + v*(`vec_space`<<5). Here v is the index of the highest set bit among bits 7..1 of `int_pend & int_en`, or 0 when none of those bits is set.
- R5: For general exceptions the handler PC is the base plus the offset. The base is 0xBFC00200 when `st_bev`=1, and `exc_base` with bits 9..0 cleared otherwise.
- R6: `cause_code` is loaded for general exceptions only, mapped by kind: 0..13 map to themselves, 14 (floating point)→15, 15 (watch)→23, 16 (machine check)→24, 17 (cache error)→30. Kinds 1..13 are: modify, TLB load, TLB store, address error load, address error store, instruction bus error, data bus error, syscall, break, reserved instruction, coprocessor unusable, overflow, trap.
- R7: A non-maskable interrupt (kind 18) or soft reset (kind 19) loads `err_epc` with the return address. It sets `new_erl`, `new_bev` and `new_kern` to 1, keeps `new_exl`=`st_exl`, and jumps to 0xBFC00000. It leaves `epc` and `cause_code` unchanged, and clears `cause_bd` if `st_exl` was 0.
- R8: A debug exception (kind 20) loads `dbg_epc` with the return address and jumps to 0xBFC00480. It sets `new_kern` to 1, passes the other status bits through, leaves `epc` and `cause_code` unchanged, and clears `cause_bd` if `st_exl` was 0.
- R9: A cache error (kind 17) uses offset 0x100 when `st_bev`=1, and 0x20000100 otherwise.
- R10: All results appear on the clock edge that samples `req`. `vec_valid` is high for exactly the cycle after each accepted request, and no output register changes without one. Kinds 21..31, or `req`=0, are ignored.
- R11: Synchronous active-high reset clears every output register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | One-cycle exception request strobe |
| req_kind | input | 5 | Exception kind code (see R6, R7, R8) |
| cur_pc | input | PC_W | PC of the faulting instruction |
| in_dly | input | 1 | Exception taken in a branch delay slot |
| dly_compact | input | 1 | The branch owning the slot is a 16-bit encoding |
| isa_compact | input | 1 | Compressed ISA mode active |
| refill | input | 1 | TLB miss had no matching entry |
| st_exl | input | 1 | Current exception-level bit |
| st_erl | input | 1 | Current error-level bit |
| st_bev | input | 1 | Current bootstrap-vector bit |
| exc_base | input | PC_W | Exception base address |
| int_iv | input | 1 | Dedicated interrupt vector enable |
| vec_mode | input | 1 | Vectored interrupt mode enable |
| vec_space | input | VS_W | Vector spacing field |
| int_pend | input | NLINES | Pending interrupt lines |
| int_en | input | NLINES | Interrupt line enables |
| vec_valid | output | 1 | Handler PC valid pulse |
| vec_pc | output | PC_W | Handler PC |
| cause_code | output | 5 | Exception cause code |
| cause_bd | output | 1 | Branch-delay cause bit |
| epc | output | PC_W | Return address for general exceptions |
| err_epc | output | PC_W | Return address for error-level exceptions |
| dbg_epc | output | PC_W | Return address for debug exceptions |
| new_exl | output | 1 | Updated exception-level bit |
| new_erl | output | 1 | Updated error-level bit |
| new_bev | output | 1 | Updated bootstrap-vector bit |
| new_kern | output | 1 | Kernel mode forced |

## Verification
Every result of the unit (handler PC, cause, the three return-address registers, branch-delay bit and new status bits) is registered on the edge that samples `req`. All of them are therefore due exactly one cycle after the request. The bench drives each request on a falling edge, holds `req` high for one cycle, and samples every output on the next falling edge, while `vec_valid` is high. Requirements about values that must stay put (a set exception level, error and debug kinds, ignored kinds) are checked by reading the held registers in that same cycle.

// File: rtl/excvec_pkg.sv
package excvec_pkg;

    typedef enum logic [4:0] {
        EK_INT   = 5'd0,
        EK_MOD   = 5'd1,
        EK_TLBL  = 5'd2,
        EK_TLBS  = 5'd3,
        EK_ADEL  = 5'd4,
        EK_ADES  = 5'd5,
        EK_IBE   = 5'd6,
        EK_DBE   = 5'd7,
        EK_SYS   = 5'd8,
        EK_BRK   = 5'd9,
        EK_RI    = 5'd10,
        EK_CPU   = 5'd11,
        EK_OVF   = 5'd12,
        EK_TRAP  = 5'd13,
        EK_FPE   = 5'd14,
        EK_WATCH = 5'd15,
        EK_MCHK  = 5'd16,
        EK_CACHE = 5'd17,
        EK_NMI   = 5'd18,
        EK_SRST  = 5'd19,
        EK_DEBUG = 5'd20
    } exc_kind_e;

    typedef enum logic [1:0] {
        CL_NONE = 2'd0,
        CL_GEN  = 2'd1,
        CL_ERR  = 2'd2,
        CL_DBG  = 2'd3
    } exc_class_e;

    typedef struct packed {
        logic exl;
        logic erl;
        logic bev;
        logic kern;
    } stat_t;

    localparam logic [31:0] VEC_BOOT_BASE = 32'hBFC0_0200;
    localparam logic [31:0] VEC_ERR       = 32'hBFC0_0000;
    localparam logic [31:0] VEC_DBG       = 32'hBFC0_0480;
    localparam logic [31:0] OFF_GEN       = 32'h0000_0180;
    localparam logic [31:0] OFF_REFILL    = 32'h0000_0000;
    localparam logic [31:0] OFF_INTV      = 32'h0000_0200;
    localparam logic [31:0] OFF_CERR_BOOT = 32'h0000_0100;
    localparam logic [31:0] OFF_CERR_BASE = 32'h2000_0100;
    localparam int          BASE_ALIGN    = 10;
    localparam int          SPACE_SHIFT   = 5;

    function automatic exc_class_e class_of(input logic [4:0] k);
        if (k <= 5'd17)
            return CL_GEN;
        else if (k == 5'd18 || k == 5'd19)
            return CL_ERR;
        else if (k == 5'd20)
            return CL_DBG;
        else
            return CL_NONE;
    endfunction

    function automatic logic [4:0] cause_of(input logic [4:0] k);
        case (k)
            EK_FPE:   return 5'd15;
            EK_WATCH: return 5'd23;
            EK_MCHK:  return 5'd24;
            EK_CACHE: return 5'd30;
            default:  return k;
        endcase
    endfunction

endpackage

// File: rtl/excvec_resume.sv
module excvec_resume #(
    parameter int PC_W = 32
) (
    input  logic [PC_W-1:0] cur_pc,
    input  logic            isa_compact,
    input  logic            in_dly,
    input  logic            dly_compact,
    output logic [PC_W-1:0] resume_pc
);
    localparam logic [PC_W-1:0] STEP_SHORT = PC_W'(2);
    localparam logic [PC_W-1:0] STEP_LONG  = PC_W'(4);

    logic [PC_W-1:0] tagged_pc;

    always_comb begin
        tagged_pc = cur_pc | PC_W'(isa_compact);
        if (in_dly)
            resume_pc = tagged_pc - (dly_compact ? STEP_SHORT : STEP_LONG);
        else
            resume_pc = tagged_pc;
    end
endmodule

// File: rtl/excvec_prio.sv
module excvec_prio #(
    parameter int NLINES = 8,
    localparam int IDX_W = $clog2(NLINES)
) (
    input  logic [NLINES-1:0] int_pend,
    input  logic [NLINES-1:0] int_en,
    output logic [IDX_W-1:0]  vec_idx
);
    logic [NLINES-1:0] live;

    for (genvar g = 0; g < NLINES; g++) begin : g_mask
        assign live[g] = int_pend[g] & int_en[g];
    end

    always_comb begin
        vec_idx = '0;
        for (int i = 1; i < NLINES; i++) begin
            if (live[i])
                vec_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/excvec_offset.sv
module excvec_offset
    import excvec_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int NLINES = 8,
    parameter int VS_W   = 6,
    localparam int IDX_W = $clog2(NLINES)
) (
    input  logic [4:0]      req_kind,
    input  logic            refill,
    input  logic            st_exl,
    input  logic            st_bev,
    input  logic            int_iv,
    input  logic            vec_mode,
    input  logic [VS_W-1:0] vec_space,
    input  logic [IDX_W-1:0] vec_idx,
    output logic [PC_W-1:0] offset
);
    localparam logic [PC_W-1:0] O_GEN   = PC_W'(OFF_GEN);
    localparam logic [PC_W-1:0] O_REF   = PC_W'(OFF_REFILL);
    localparam logic [PC_W-1:0] O_INTV  = PC_W'(OFF_INTV);
    localparam logic [PC_W-1:0] O_CBOOT = PC_W'(OFF_CERR_BOOT);
    localparam logic [PC_W-1:0] O_CBASE = PC_W'(OFF_CERR_BASE);

    logic [PC_W-1:0] spacing;
    logic [PC_W-1:0] vec_off;
    logic            is_tlb;

    assign spacing = PC_W'(vec_space) << SPACE_SHIFT;
    assign vec_off = O_INTV + PC_W'(vec_idx) * spacing;
    assign is_tlb  = (req_kind == EK_TLBL) || (req_kind == EK_TLBS);

    always_comb begin
        if (req_kind == EK_CACHE)
            offset = st_bev ? O_CBOOT : O_CBASE;
        else if (req_kind == EK_INT)
            offset = vec_mode ? vec_off : (int_iv ? O_INTV : O_GEN);
        else if (is_tlb && refill && !st_exl)
            offset = O_REF;
        else
            offset = O_GEN;
    end
endmodule

// File: rtl/excvec_unit.sv
module excvec_unit
    import excvec_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int NLINES = 8,
    parameter int VS_W   = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [4:0]        req_kind,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic              in_dly,
    input  logic              dly_compact,
    input  logic              isa_compact,
    input  logic              refill,
    input  logic              st_exl,
    input  logic              st_erl,
    input  logic              st_bev,
    input  logic [PC_W-1:0]   exc_base,
    input  logic              int_iv,
    input  logic              vec_mode,
    input  logic [VS_W-1:0]   vec_space,
    input  logic [NLINES-1:0] int_pend,
    input  logic [NLINES-1:0] int_en,
    output logic              vec_valid,
    output logic [PC_W-1:0]   vec_pc,
    output logic [4:0]        cause_code,
    output logic              cause_bd,
    output logic [PC_W-1:0]   epc,
    output logic [PC_W-1:0]   err_epc,
    output logic [PC_W-1:0]   dbg_epc,
    output logic              new_exl,
    output logic              new_erl,
    output logic              new_bev,
    output logic              new_kern
);
    localparam int IDX_W = $clog2(NLINES);
    localparam logic [PC_W-1:0] BOOT_BASE = PC_W'(VEC_BOOT_BASE);
    localparam logic [PC_W-1:0] ERR_PC    = PC_W'(VEC_ERR);
    localparam logic [PC_W-1:0] DBG_PC    = PC_W'(VEC_DBG);
    localparam logic [PC_W-1:0] ALIGN_MSK = ~((PC_W'(1) << BASE_ALIGN) - PC_W'(1));

    logic [PC_W-1:0]  resume_pc;
    logic [IDX_W-1:0] vec_idx;
    logic [PC_W-1:0]  offset;
    logic [PC_W-1:0]  base;
    logic [PC_W-1:0]  target;
    exc_class_e       cls;
    logic             take;
    stat_t            stat_nx;

    excvec_resume #(.PC_W(PC_W)) u_resume (
        .cur_pc      (cur_pc),
        .isa_compact (isa_compact),
        .in_dly      (in_dly),
        .dly_compact (dly_compact),
        .resume_pc   (resume_pc)
    );

    excvec_prio #(.NLINES(NLINES)) u_prio (
        .int_pend (int_pend),
        .int_en   (int_en),
        .vec_idx  (vec_idx)
    );

    excvec_offset #(.PC_W(PC_W), .NLINES(NLINES), .VS_W(VS_W)) u_offset (
        .req_kind  (req_kind),
        .refill    (refill),
        .st_exl    (st_exl),
        .st_bev    (st_bev),
        .int_iv    (int_iv),
        .vec_mode  (vec_mode),
        .vec_space (vec_space),
        .vec_idx   (vec_idx),
        .offset    (offset)
    );

    assign cls  = class_of(req_kind);
    assign take = req && (cls != CL_NONE);
    assign base = st_bev ? BOOT_BASE : (exc_base & ALIGN_MSK);

    always_comb begin
        target  = base + offset;
        stat_nx = '{exl: st_exl, erl: st_erl, bev: st_bev, kern: 1'b1};
        case (cls)
            CL_GEN: stat_nx.exl = 1'b1;
            CL_ERR: begin
                target      = ERR_PC;
                stat_nx.erl = 1'b1;
                stat_nx.bev = 1'b1;
            end
            CL_DBG: target = DBG_PC;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_valid  <= 1'b0;
            vec_pc     <= '0;
            cause_code <= '0;
            cause_bd   <= 1'b0;
            epc        <= '0;
            err_epc    <= '0;
            dbg_epc    <= '0;
            new_exl    <= 1'b0;
            new_erl    <= 1'b0;
            new_bev    <= 1'b0;
            new_kern   <= 1'b0;
        end else begin
            vec_valid <= take;
            if (take) begin
                vec_pc   <= target;
                new_exl  <= stat_nx.exl;
                new_erl  <= stat_nx.erl;
                new_bev  <= stat_nx.bev;
                new_kern <= stat_nx.kern;
                case (cls)
                    CL_GEN: begin
                        cause_code <= cause_of(req_kind);
                        if (!st_exl) begin
                            epc      <= resume_pc;
                            cause_bd <= in_dly;
                        end
                    end
                    CL_ERR: begin
                        err_epc <= resume_pc;
                        if (!st_exl)
                            cause_bd <= 1'b0;
                    end
                    CL_DBG: begin
                        dbg_epc <= resume_pc;
                        if (!st_exl)
                            cause_bd <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/excvec_chk.sv
module excvec_chk
    import excvec_pkg::*;
#(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            req,
    input logic [4:0]      req_kind,
    input logic            st_exl,
    input logic            st_bev,
    input logic            vec_valid,
    input logic [PC_W-1:0] vec_pc,
    input logic [4:0]      cause_code,
    input logic            cause_bd,
    input logic [PC_W-1:0] epc,
    input logic [PC_W-1:0] err_epc,
    input logic [PC_W-1:0] dbg_epc,
    input logic            new_exl,
    input logic            new_erl,
    input logic            new_bev,
    input logic            new_kern
);
    assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(req) |-> !vec_valid);

    assert_regs_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !vec_valid |-> ($stable(epc) && $stable(err_epc) && $stable(dbg_epc)
                        && $stable(cause_code) && $stable(cause_bd)));

    assert_exl_keeps_epc_R2: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && $past(st_exl) && ($past(req_kind) <= 5'd17))
        |-> ($stable(epc) && $stable(cause_bd)));

    assert_gen_status_R2: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && ($past(req_kind) <= 5'd17)) |-> (new_exl && new_kern));

    assert_boot_region_R5: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && $past(st_bev) && ($past(req_kind) <= 5'd17))
        |-> (vec_pc[PC_W-1:PC_W-16] == 16'hBFC0));

    assert_err_entry_R7: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && (($past(req_kind) == 5'd18) || ($past(req_kind) == 5'd19)))
        |-> ((vec_pc == PC_W'(VEC_ERR)) && new_erl && new_bev && $stable(epc)
             && $stable(cause_code)));

    assert_dbg_entry_R8: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && ($past(req_kind) == 5'd20))
        |-> ((vec_pc == PC_W'(VEC_DBG)) && $stable(epc) && $stable(err_epc)));
endmodule

bind excvec_unit excvec_chk #(.PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .req_kind   (req_kind),
    .st_exl     (st_exl),
    .st_bev     (st_bev),
    .vec_valid  (vec_valid),
    .vec_pc     (vec_pc),
    .cause_code (cause_code),
    .cause_bd   (cause_bd),
    .epc        (epc),
    .err_epc    (err_epc),
    .dbg_epc    (dbg_epc),
    .new_exl    (new_exl),
    .new_erl    (new_erl),
    .new_bev    (new_bev),
    .new_kern   (new_kern)
);

// File: tb/excvec_unit_bench.sv
`timescale 1ns/1ps
module excvec_unit_bench;
    localparam int PC_W = 32;
    localparam int NLINES = 8;
    localparam int VS_W = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic [4:0] req_kind = '0;
    logic [PC_W-1:0] cur_pc = '0;
    logic in_dly = 1'b0, dly_compact = 1'b0, isa_compact = 1'b0, refill = 1'b0;
    logic st_exl = 1'b0, st_erl = 1'b0, st_bev = 1'b0;
    logic [PC_W-1:0] exc_base = 32'h8000_0000;
    logic int_iv = 1'b0, vec_mode = 1'b0;
    logic [VS_W-1:0] vec_space = '0;
    logic [NLINES-1:0] int_pend = '0, int_en = '0;
    logic vec_valid, cause_bd, new_exl, new_erl, new_bev, new_kern;
    logic [PC_W-1:0] vec_pc, epc, err_epc, dbg_epc;
    logic [4:0] cause_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    excvec_unit #(.PC_W(PC_W), .NLINES(NLINES), .VS_W(VS_W)) u_excvec_unit (
        .clk(clk), .rst(rst), .req(req), .req_kind(req_kind), .cur_pc(cur_pc),
        .in_dly(in_dly), .dly_compact(dly_compact), .isa_compact(isa_compact),
        .refill(refill), .st_exl(st_exl), .st_erl(st_erl), .st_bev(st_bev),
        .exc_base(exc_base), .int_iv(int_iv), .vec_mode(vec_mode),
        .vec_space(vec_space), .int_pend(int_pend), .int_en(int_en),
        .vec_valid(vec_valid), .vec_pc(vec_pc), .cause_code(cause_code),
        .cause_bd(cause_bd), .epc(epc), .err_epc(err_epc), .dbg_epc(dbg_epc),
        .new_exl(new_exl), .new_erl(new_erl), .new_bev(new_bev), .new_kern(new_kern)
    );

    typedef struct packed {
        logic [4:0]  kind;
        logic [31:0] pc;
        logic        dly;
        logic        cbr;
        logic        isa;
        logic        rfl;
        logic        bev;
        logic [31:0] ebase;
        logic        iv;
        logic        vm;
        logic [5:0]  vs;
        logic [7:0]  pend;
        logic [7:0]  en;
        logic [31:0] x_pc;
        logic [4:0]  x_cause;
        logic [31:0] x_epc;
        logic        x_bd;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{5'd8,  32'h1000, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_0000, 1'b0,1'b0,6'd0, 8'h00,8'h00, 32'h8000_0180, 5'd8,  32'h1000, 1'b0},
        '{5'd9,  32'h2000, 1'b1,1'b0,1'b0,1'b0,1'b1, 32'h8000_0000, 1'b0,1'b0,6'd0, 8'h00,8'h00, 32'hBFC0_0380, 5'd9,  32'h1FFC, 1'b1},
        '{5'd10, 32'h3000, 1'b1,1'b1,1'b1,1'b0,1'b0, 32'h9000_03FF, 1'b0,1'b0,6'd0, 8'h00,8'h00, 32'h9000_0180, 5'd10, 32'h2FFF, 1'b1},
        '{5'd2,  32'h4000, 1'b0,1'b0,1'b0,1'b1,1'b0, 32'h8000_1000, 1'b0,1'b0,6'd0, 8'h00,8'h00, 32'h8000_1000, 5'd2,  32'h4000, 1'b0},
        '{5'd3,  32'h4004, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_1000, 1'b0,1'b0,6'd0, 8'h00,8'h00, 32'h8000_1180, 5'd3,  32'h4004, 1'b0},
        '{5'd3,  32'h4008, 1'b0,1'b0,1'b0,1'b1,1'b1, 32'h8000_0000, 1'b0,1'b0,6'd0, 8'h00,8'h00, 32'hBFC0_0200, 5'd3,  32'h4008, 1'b0},
        '{5'd0,  32'h5000, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_0000, 1'b0,1'b0,6'd0, 8'h00,8'h00, 32'h8000_0180, 5'd0,  32'h5000, 1'b0},
        '{5'd0,  32'h5004, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_0000, 1'b1,1'b0,6'd0, 8'h00,8'h00, 32'h8000_0200, 5'd0,  32'h5004, 1'b0},
        '{5'd0,  32'h5008, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_0000, 1'b0,1'b1,6'd1, 8'hA6,8'h27, 32'h8000_02A0, 5'd0,  32'h5008, 1'b0},
        '{5'd0,  32'h500C, 1'b0,1'b0,1'b0,1'b0,1'b1, 32'h8000_0000, 1'b0,1'b1,6'd3, 8'h01,8'hFF, 32'hBFC0_0400, 5'd0,  32'h500C, 1'b0},
        '{5'd0,  32'h5010, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_0000, 1'b1,1'b1,6'd63,8'h80,8'h80, 32'h8000_3920, 5'd0,  32'h5010, 1'b0},
        '{5'd0,  32'h5014, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_0000, 1'b0,1'b1,6'd2, 8'hFE,8'h00, 32'h8000_0200, 5'd0,  32'h5014, 1'b0},
        '{5'd17, 32'h6000, 1'b0,1'b0,1'b0,1'b0,1'b1, 32'h8000_0000, 1'b0,1'b0,6'd0, 8'h00,8'h00, 32'hBFC0_0300, 5'd30, 32'h6000, 1'b0},
        '{5'd17, 32'h6004, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_0000, 1'b0,1'b0,6'd0, 8'h00,8'h00, 32'hA000_0100, 5'd30, 32'h6004, 1'b0},
        '{5'd14, 32'h6008, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_0000, 1'b0,1'b0,6'd0, 8'h00,8'h00, 32'h8000_0180, 5'd15, 32'h6008, 1'b0},
        '{5'd15, 32'h600C, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_0000, 1'b0,1'b0,6'd0, 8'h00,8'h00, 32'h8000_0180, 5'd23, 32'h600C, 1'b0},
        '{5'd16, 32'h6010, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_0000, 1'b0,1'b0,6'd0, 8'h00,8'h00, 32'h8000_0180, 5'd24, 32'h6010, 1'b0},
        '{5'd1,  32'h6014, 1'b0,1'b0,1'b0,1'b1,1'b0, 32'h8000_0000, 1'b0,1'b0,6'd0, 8'h00,8'h00, 32'h8000_0180, 5'd1,  32'h6014, 1'b0},
        '{5'd5,  32'h6018, 1'b0,1'b0,1'b0,1'b1,1'b0, 32'h8000_0000, 1'b0,1'b0,6'd0, 8'h00,8'h00, 32'h8000_0180, 5'd5,  32'h6018, 1'b0},
        '{5'd11, 32'h601C, 1'b1,1'b1,1'b0,1'b0,1'b0, 32'h8000_0000, 1'b0,1'b0,6'd0, 8'h00,8'h00, 32'h8000_0180, 5'd11, 32'h601A, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic fire(input logic [4:0] k, input logic [31:0] pc,
                        input logic dly, input logic cbr, input logic isa);
        @(negedge clk);
        req_kind = k; cur_pc = pc; in_dly = dly; dly_compact = cbr; isa_compact = isa;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 vec_valid", 32'(vec_valid), 32'd0);
        chk("R11 vec_pc", vec_pc, 32'd0);
        chk("R11 epc", epc, 32'd0);
        chk("R11 status", {28'd0, new_exl, new_erl, new_bev, new_kern}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            refill = TBL[i].rfl; st_bev = TBL[i].bev; exc_base = TBL[i].ebase;
            int_iv = TBL[i].iv; vec_mode = TBL[i].vm; vec_space = TBL[i].vs;
            int_pend = TBL[i].pend; int_en = TBL[i].en; st_exl = 1'b0; st_erl = 1'b0;
            fire(TBL[i].kind, TBL[i].pc, TBL[i].dly, TBL[i].cbr, TBL[i].isa);
            chk($sformatf("R10 valid row %0d", i), 32'(vec_valid), 32'd1);
            chk($sformatf("R3 R4 R5 R9 vec_pc row %0d", i), vec_pc, TBL[i].x_pc);
            chk($sformatf("R6 cause row %0d", i), 32'(cause_code), 32'(TBL[i].x_cause));
            chk($sformatf("R1 epc row %0d", i), epc, TBL[i].x_epc);
            chk($sformatf("R2 bd row %0d", i), 32'(cause_bd), 32'(TBL[i].x_bd));
            chk($sformatf("R2 status row %0d", i), {28'd0, new_exl, new_erl, new_bev, new_kern},
                {28'd0, 1'b1, 1'b0, TBL[i].bev, 1'b1});
        end
        refill = 1'b0; st_bev = 1'b0; exc_base = 32'h8000_0000;
        int_iv = 1'b0; vec_mode = 1'b0; vec_space = '0; int_pend = '0; int_en = '0;

        // R2: exception level set keeps epc and bd
        st_exl = 1'b1;
        fire(5'd8, 32'h7000, 1'b0, 1'b0, 1'b0);
        chk("R2 epc kept", epc, 32'h601A);
        chk("R2 bd kept", 32'(cause_bd), 32'd1);
        chk("R6 cause under exl", 32'(cause_code), 32'd8);
        chk("R2 exl kern", {30'd0, new_exl, new_kern}, 32'd3);

        // R3: refill with exl set falls back to general offset
        refill = 1'b1;
        fire(5'd2, 32'h7004, 1'b0, 1'b0, 1'b0);
        chk("R3 refill under exl", vec_pc, 32'h8000_0180);
        refill = 1'b0;
        st_exl = 1'b0;

        // R7: NMI
        fire(5'd18, 32'h8000, 1'b0, 1'b0, 1'b1);
        chk("R7 nmi pc", vec_pc, 32'hBFC0_0000);
        chk("R7 nmi err_epc", err_epc, 32'h8001);
        chk("R7 nmi status", {28'd0, new_exl, new_erl, new_bev, new_kern}, 32'b0111);
        chk("R7 nmi epc kept", epc, 32'h601A);
        chk("R7 nmi cause kept", 32'(cause_code), 32'd2);
        chk("R7 nmi bd cleared", 32'(cause_bd), 32'd0);

        // R7: soft reset from a delay slot
        fire(5'd19, 32'h8100, 1'b1, 1'b0, 1'b0);
        chk("R7 srst err_epc", err_epc, 32'h80FC);
        chk("R7 srst pc", vec_pc, 32'hBFC0_0000);

        // R8: debug
        fire(5'd20, 32'h8200, 1'b1, 1'b1, 1'b0);
        chk("R8 dbg pc", vec_pc, 32'hBFC0_0480);
        chk("R8 dbg_epc", dbg_epc, 32'h81FE);
        chk("R8 dbg status", {28'd0, new_exl, new_erl, new_bev, new_kern}, 32'b0001);
        chk("R8 dbg err_epc kept", err_epc, 32'h80FC);

        // R10: unused kind ignored
        fire(5'd25, 32'h9000, 1'b0, 1'b0, 1'b0);
        chk("R10 bad kind valid", 32'(vec_valid), 32'd0);
        chk("R10 bad kind epc", epc, 32'h601A);
        chk("R10 bad kind pc", vec_pc, 32'hBFC0_0480);

        // R10: no request, no change
        @(negedge clk);
        req_kind = 5'd8; cur_pc = 32'hA000;
        @(negedge clk);
        chk("R10 idle valid", 32'(vec_valid), 32'd0);
        chk("R10 idle epc", epc, 32'h601A);

        // R10: back-to-back requests each complete in one cycle
        @(negedge clk);
        req_kind = 5'd12; cur_pc = 32'hB000; in_dly = 1'b0; isa_compact = 1'b0; req = 1'b1;
        @(negedge clk);
        chk("R10 b2b first epc", epc, 32'hB000);
        req_kind = 5'd13; cur_pc = 32'hB004;
        @(negedge clk);
        req = 1'b0;
        chk("R10 b2b second valid", 32'(vec_valid), 32'd1);
        chk("R6 b2b cause", 32'(cause_code), 32'd13);
        @(negedge clk);
        chk("R10 pulse ends", 32'(vec_valid), 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule